// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

After reset, this block owns the command pins of an SDRAM device. It brings the memory out of power-up by issuing a fixed series of commands: clock enable, precharge-all, extended and base mode-register loads, and auto-refreshes. A programmed number of idle cycles follows each command. The memory family (SDR, DDR, LPDDR or DDR2), the CAS latency and the number of command phases per controller clock are elaboration parameters. From these the block derives which steps are present, which bank each extended load targets, and the value written to the mode register.

While the series runs, the block drives the phase-0 command port itself and ignores the controller's command inputs. When the wait after the last step has elapsed, it raises a done flag that stays high until the next reset. From then on a multiplexer passes the controller's command inputs straight through to the memory pins.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, `mem_cke` is low, `init_done` is low, and the command pins carry a NOP: `mem_cs_n`=0, `mem_ras_n`=1, `mem_cas_n`=1, `mem_we_n`=1.
- R2: In the first cycle after reset is released, `mem_cke` rises with address 0 and bank 0 and the command pins at NOP. The next command follows `PWRUP_WAIT` (2000) cycles later.
- R3: Command pin encodings, written as {cs_n,ras_n,cas_n,we_n}: precharge-all is 0,0,1,0 with address 0x400 on bank 0; mode-register load is 0,0,0,0; auto-refresh is 0,0,0,1 with address 0 on bank 0.
- R4: For DDR2 (`MEM_KIND`=3) the order is: clock enable, precharge-all, load on bank 3, load on bank 2, load on bank 1 (all three with value 0), base load with DLL reset, precharge-all, two auto-refreshes, base load, load on bank 1 with 0x380, and load on bank 1 with 0.
- R5: For SDR (`MEM_KIND`=0) there is no extended load. For DDR (1) a single extended load of 0 goes to bank 1, and for LPDDR (2) it goes to bank 2. In each case it comes directly before the DLL-reset load.
- R6: If a step is issued in cycle t with wait W, the next step is issued in cycle t+1+W. Precharge-all and the extended loads have W=0, the two base loads have `MODE_WAIT` (200), and each auto-refresh has `REF_WAIT` (4).
- R7: The base mode value is log2(BL) + (CL<<4), with BL = PHASES for SDR and 2*PHASES otherwise. DDR2 adds 0x400 for write recovery. The first base load also sets bit 8 (DLL reset) and the second does not.
- R8: Every command is driven for exactly one cycle, and all other cycles of the sequence are NOPs. Once raised, `mem_cke` stays high until the sequence finishes.
- R9: Until `init_done` rises, the `ctl_*` inputs have no effect on any `mem_*` output.
- R10: `init_done` rises 1+W cycles after the last step is issued and stays high until reset. From then on every `mem_*` output equals the matching `ctl_*` input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_addr | input | ADDR_W | Controller address |
| ctl_bank | input | BANK_W | Controller bank |
| ctl_cs_n | input | 1 | Controller chip select, active low |
| ctl_ras_n | input | 1 | Controller row strobe, active low |
| ctl_cas_n | input | 1 | Controller column strobe, active low |
| ctl_we_n | input | 1 | Controller write enable, active low |
| ctl_cke | input | 1 | Controller clock enable |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_bank | output | BANK_W | Bank to the memory |
| mem_cs_n | output | 1 | Chip select to the memory |
| mem_ras_n | output | 1 | Row strobe to the memory |
| mem_cas_n | output | 1 | Column strobe to the memory |
| mem_we_n | output | 1 | Write enable to the memory |
| mem_cke | output | 1 | Clock enable to the memory |
| init_done | output | 1 | Sequence finished; controller owns the pins |

## Verification
The hardest case to produce is proof that no controller command leaks onto the pins during the sequence. A leak would show up only as a stray or distorted command in one cycle out of about 2400. To expose it, the stimulus drives the controller inputs with a pattern that changes every cycle, holds `ctl_cke` low and asserts chip select. Any leak then appears as an unexpected command or a dropped clock enable. Four instances, one per memory family, run side by side. Every observed command is compared against an expected list with exact cycle numbers, so a wrong wait of even one cycle, or a bank swapped between extended loads, is caught.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int KIND_SDR   = 0;
  localparam int KIND_DDR   = 1;
  localparam int KIND_LPDDR = 2;
  localparam int KIND_DDR2  = 3;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CKE  = 3'd1,
    OP_PRE  = 3'd2,
    OP_LMR  = 3'd3,
    OP_REF  = 3'd4
  } init_op_e;

  localparam int PRE_ALL_ADDR = 32'h400;
  localparam int DLL_RST_BIT  = 32'h100;
  localparam int OCD_DEFAULT  = 32'h380;
  localparam int DDR2_WR_FLD  = 2 << 9;

  // number of extended loads placed before the DLL-reset load
  function automatic int ext_loads(input int kind);
    case (kind)
      KIND_SDR:  return 0;
      KIND_DDR2: return 3;
      default:   return 1;
    endcase
  endfunction

  function automatic int step_total(input int kind);
    return 7 + ext_loads(kind) + ((kind == KIND_DDR2) ? 2 : 0);
  endfunction

  function automatic int ceil_log2(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  function automatic int mode_value(input int kind, input int cl, input int phases);
    int bl;
    bl = (kind == KIND_SDR) ? phases : 2 * phases;
    return ceil_log2(bl) + (cl << 4) + ((kind == KIND_DDR2) ? DDR2_WR_FLD : 0);
  endfunction

  // step role relative to the end of the extended-load group
  function automatic int tail_pos(input int kind, input int idx);
    return idx - 2 - ext_loads(kind);
  endfunction

  function automatic init_op_e step_op(input int kind, input int idx);
    int t;
    t = tail_pos(kind, idx);
    if (idx == 0) return OP_CKE;
    if (idx == 1) return OP_PRE;
    if (t < 0) return OP_LMR;
    case (t)
      1:       return OP_PRE;
      2, 3:    return OP_REF;
      default: return OP_LMR;
    endcase
  endfunction

  function automatic int step_addr(input int kind, input int cl, input int phases, input int idx);
    int t;
    t = tail_pos(kind, idx);
    if (idx == 0) return 0;
    if (idx == 1) return PRE_ALL_ADDR;
    if (t < 0) return 0;
    case (t)
      0:       return mode_value(kind, cl, phases) + DLL_RST_BIT;
      1:       return PRE_ALL_ADDR;
      4:       return mode_value(kind, cl, phases);
      5:       return OCD_DEFAULT;
      default: return 0;
    endcase
  endfunction

  function automatic int step_bank(input int kind, input int idx);
    int t;
    t = tail_pos(kind, idx);
    if (idx < 2) return 0;
    if (t < 0) begin
      if (kind == KIND_DDR2) return 3 - (idx - 2);
      if (kind == KIND_LPDDR) return 2;
      return 1;
    end
    if (t >= 5) return 1;
    return 0;
  endfunction

  function automatic int step_hold(input int kind, input int idx,
                                   input int pwr_w, input int mode_w, input int ref_w);
    int t;
    t = tail_pos(kind, idx);
    if (idx == 0) return pwr_w;
    if (idx == 1 || t < 0) return 0;
    case (t)
      0, 4:    return mode_w;
      2, 3:    return ref_w;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] hold,
  output logic             busy,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= hold;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sdram_init_step_rom.sv
module sdram_init_step_rom
  import sdram_init_pkg::*;
#(
  parameter int MEM_KIND   = KIND_DDR2,
  parameter int CAS_LAT    = 3,
  parameter int PHASES     = 2,
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 2,
  parameter int CNT_W      = 11,
  parameter int IDX_W      = 4,
  parameter int PWRUP_WAIT = 2000,
  parameter int MODE_WAIT  = 200,
  parameter int REF_WAIT   = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output init_op_e          op,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [CNT_W-1:0]  hold,
  output logic              last
);
  localparam int STEPS = step_total(MEM_KIND);

  assign op   = step_op(MEM_KIND, int'(idx));
  assign addr = ADDR_W'(step_addr(MEM_KIND, CAS_LAT, PHASES, int'(idx)));
  assign bank = BANK_W'(step_bank(MEM_KIND, int'(idx)));
  assign hold = CNT_W'(step_hold(MEM_KIND, int'(idx), PWRUP_WAIT, MODE_WAIT, REF_WAIT));
  assign last = (int'(idx) == STEPS - 1);
endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  init_op_e         op,
  input  logic             hold_zero,
  input  logic             last,
  input  logic             expire,
  output logic [IDX_W-1:0] idx,
  output logic             issue_now,
  output logic             cke_out,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} ctl_state_e;

  ctl_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             cke_q;
  logic             step_end;

  // a step is finished when its wait is zero at issue, or its wait expires
  assign step_end = (state_q == S_ISSUE && hold_zero) || (state_q == S_WAIT && expire);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cke_q   <= 1'b0;
    end else begin
      if (state_q == S_ISSUE && op == OP_CKE) cke_q <= 1'b1;
      case (state_q)
        S_IDLE:  state_q <= S_ISSUE;
        S_ISSUE: if (!hold_zero) state_q <= S_WAIT;
        default: ;
      endcase
      if (step_end) begin
        if (last) state_q <= S_DONE;
        else begin
          state_q <= S_ISSUE;
          idx_q   <= idx_q + 1'b1;
        end
      end
    end
  end

  assign idx       = idx_q;
  assign issue_now = (state_q == S_ISSUE);
  assign cke_out   = cke_q || (issue_now && op == OP_CKE);
  assign done      = (state_q == S_DONE);
endmodule

// File: rtl/sdram_cmd_mux.sv
module sdram_cmd_mux
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              sel_ctl,
  input  logic              seq_active,
  input  init_op_e          seq_op,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [BANK_W-1:0] seq_bank,
  input  logic              seq_cke,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [BANK_W-1:0] ctl_bank,
  input  logic [3:0]        ctl_pins,
  input  logic              ctl_cke,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BANK_W-1:0] out_bank,
  output logic [3:0]        out_pins,
  output logic              out_cke,
  output logic              seq_is_nop
);
  logic [3:0]        enc_pins;
  logic [ADDR_W-1:0] enc_addr;
  logic [BANK_W-1:0] enc_bank;

  // pins ordered {cs_n, ras_n, cas_n, we_n}
  always_comb begin
    enc_pins = 4'b0111;
    enc_addr = '0;
    enc_bank = '0;
    if (seq_active) begin
      enc_addr = seq_addr;
      enc_bank = seq_bank;
      case (seq_op)
        OP_PRE:  enc_pins = 4'b0010;
        OP_LMR:  enc_pins = 4'b0000;
        OP_REF:  enc_pins = 4'b0001;
        default: enc_pins = 4'b0111;
      endcase
    end
  end

  assign seq_is_nop = (enc_pins == 4'b0111);

  assign out_addr = sel_ctl ? ctl_addr : enc_addr;
  assign out_bank = sel_ctl ? ctl_bank : enc_bank;
  assign out_pins = sel_ctl ? ctl_pins : enc_pins;
  assign out_cke  = sel_ctl ? ctl_cke  : seq_cke;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int MEM_KIND   = KIND_DDR2,
  parameter int CAS_LAT    = 3,
  parameter int PHASES     = 2,
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 2,
  parameter int PWRUP_WAIT = 2000,
  parameter int MODE_WAIT  = 200,
  parameter int REF_WAIT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [BANK_W-1:0] ctl_bank,
  input  logic              ctl_cs_n,
  input  logic              ctl_ras_n,
  input  logic              ctl_cas_n,
  input  logic              ctl_we_n,
  input  logic              ctl_cke,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANK_W-1:0] mem_bank,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cke,
  output logic              init_done
);
  localparam int STEPS    = step_total(MEM_KIND);
  localparam int IDX_W    = $clog2(STEPS);
  localparam int MAX_WAIT = (PWRUP_WAIT > MODE_WAIT) ?
                            ((PWRUP_WAIT > REF_WAIT) ? PWRUP_WAIT : REF_WAIT) :
                            ((MODE_WAIT > REF_WAIT) ? MODE_WAIT : REF_WAIT);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic [IDX_W-1:0]  step_idx;
  init_op_e          step_kind;
  logic [ADDR_W-1:0] step_addr_w;
  logic [BANK_W-1:0] step_bank_w;
  logic [CNT_W-1:0]  step_hold_w;
  logic              step_last;
  logic              wait_busy;
  logic              wait_expire;
  logic              issue_now;
  logic              seq_cke;
  logic              seq_is_nop;
  logic [3:0]        pins;

  sdram_init_step_rom #(
    .MEM_KIND(MEM_KIND), .CAS_LAT(CAS_LAT), .PHASES(PHASES),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CNT_W(CNT_W), .IDX_W(IDX_W),
    .PWRUP_WAIT(PWRUP_WAIT), .MODE_WAIT(MODE_WAIT), .REF_WAIT(REF_WAIT)
  ) u_rom (
    .idx(step_idx), .op(step_kind), .addr(step_addr_w), .bank(step_bank_w),
    .hold(step_hold_w), .last(step_last)
  );

  sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(issue_now), .hold(step_hold_w),
    .busy(wait_busy), .expire(wait_expire)
  );

  sdram_init_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .op(step_kind), .hold_zero(step_hold_w == '0),
    .last(step_last), .expire(wait_expire), .idx(step_idx),
    .issue_now(issue_now), .cke_out(seq_cke), .done(init_done)
  );

  sdram_cmd_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
    .sel_ctl(init_done), .seq_active(issue_now), .seq_op(step_kind),
    .seq_addr(step_addr_w), .seq_bank(step_bank_w), .seq_cke(seq_cke),
    .ctl_addr(ctl_addr), .ctl_bank(ctl_bank),
    .ctl_pins({ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n}), .ctl_cke(ctl_cke),
    .out_addr(mem_addr), .out_bank(mem_bank), .out_pins(pins), .out_cke(mem_cke),
    .seq_is_nop(seq_is_nop)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = pins;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk (
  input logic clk,
  input logic rst,
  input logic mem_ras_n,
  input logic mem_cas_n,
  input logic mem_we_n,
  input logic init_done,
  input logic seq_cke,
  input logic issue_now,
  input logic wait_busy,
  input logic seq_is_nop
);
  assert_cke_held_R8: assert property (@(posedge clk) disable iff (rst)
    seq_cke |=> seq_cke);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_issue_or_wait_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({issue_now, wait_busy}));

  assert_quiet_in_wait_R6: assert property (@(posedge clk) disable iff (rst)
    wait_busy |-> seq_is_nop);

  assert_no_leak_R9: assert property (@(posedge clk) disable iff (rst)
    (!init_done && seq_is_nop) |-> (mem_ras_n && mem_cas_n && mem_we_n));

  assert_idle_when_done_R10: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (!issue_now && !wait_busy));
endmodule

bind sdram_init_seq sdram_init_chk u_chk (
  .clk(clk), .rst(rst), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .init_done(init_done), .seq_cke(seq_cke),
  .issue_now(issue_now), .wait_busy(wait_busy), .seq_is_nop(seq_is_nop)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int CLK_P = 10;
  localparam int AW = 13;
  localparam int BW = 2;
  // op codes used by the scoreboard
  localparam int E_CKE = 1, E_PRE = 2, E_LMR = 3, E_REF = 4, E_DONE = 5, E_BAD = 9;

  typedef struct { int cyc; int op; int addr; int bank; } item_t;

  logic clk = 0;
  logic rst = 1;
  logic [AW-1:0] ctl_addr = '0;
  logic [BW-1:0] ctl_bank = '0;
  logic ctl_cs_n = 1, ctl_ras_n = 1, ctl_cas_n = 1, ctl_we_n = 1, ctl_cke = 0;
  logic tog_en = 1;

  logic [AW-1:0] o_addr [4];
  logic [BW-1:0] o_bank [4];
  logic o_cs [4], o_ras [4], o_cas [4], o_we [4], o_cke [4], o_done [4];

  int checks = 0, fails = 0, cyc = 0;
  item_t q0[$], q1[$], q2[$], q3[$];
  logic prev_cke [4], prev_done [4], cke_dropped [4];

  always #(CLK_P/2) clk = ~clk;

  sdram_init_seq dut (
    .clk(clk), .rst(rst), .ctl_addr(ctl_addr), .ctl_bank(ctl_bank),
    .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n),
    .ctl_we_n(ctl_we_n), .ctl_cke(ctl_cke),
    .mem_addr(o_addr[0]), .mem_bank(o_bank[0]), .mem_cs_n(o_cs[0]),
    .mem_ras_n(o_ras[0]), .mem_cas_n(o_cas[0]), .mem_we_n(o_we[0]),
    .mem_cke(o_cke[0]), .init_done(o_done[0]));

  sdram_init_seq #(.MEM_KIND(0), .CAS_LAT(2), .PHASES(1)) u_sdr (
    .clk(clk), .rst(rst), .ctl_addr(ctl_addr), .ctl_bank(ctl_bank),
    .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n),
    .ctl_we_n(ctl_we_n), .ctl_cke(ctl_cke),
    .mem_addr(o_addr[1]), .mem_bank(o_bank[1]), .mem_cs_n(o_cs[1]),
    .mem_ras_n(o_ras[1]), .mem_cas_n(o_cas[1]), .mem_we_n(o_we[1]),
    .mem_cke(o_cke[1]), .init_done(o_done[1]));

  sdram_init_seq #(.MEM_KIND(1), .CAS_LAT(2), .PHASES(2)) u_ddr (
    .clk(clk), .rst(rst), .ctl_addr(ctl_addr), .ctl_bank(ctl_bank),
    .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n),
    .ctl_we_n(ctl_we_n), .ctl_cke(ctl_cke),
    .mem_addr(o_addr[2]), .mem_bank(o_bank[2]), .mem_cs_n(o_cs[2]),
    .mem_ras_n(o_ras[2]), .mem_cas_n(o_cas[2]), .mem_we_n(o_we[2]),
    .mem_cke(o_cke[2]), .init_done(o_done[2]));

  sdram_init_seq #(.MEM_KIND(2), .CAS_LAT(3), .PHASES(2)) u_lp (
    .clk(clk), .rst(rst), .ctl_addr(ctl_addr), .ctl_bank(ctl_bank),
    .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n),
    .ctl_we_n(ctl_we_n), .ctl_cke(ctl_cke),
    .mem_addr(o_addr[3]), .mem_bank(o_bank[3]), .mem_cs_n(o_cs[3]),
    .mem_ras_n(o_ras[3]), .mem_cas_n(o_cas[3]), .mem_we_n(o_we[3]),
    .mem_cke(o_cke[3]), .init_done(o_done[3]));

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int inst, input item_t it);
    case (inst)
      0: q0.push_back(it);
      1: q1.push_back(it);
      2: q2.push_back(it);
      default: q3.push_back(it);
    endcase
  endtask

  function automatic int qsize(input int inst);
    case (inst)
      0: return q0.size();
      1: return q1.size();
      2: return q2.size();
      default: return q3.size();
    endcase
  endfunction

  function automatic item_t qpop(input int inst);
    case (inst)
      0: return q0.pop_front();
      1: return q1.pop_front();
      2: return q2.pop_front();
      default: return q3.pop_front();
    endcase
  endfunction

  // driver: expected stream from the requirements (R2..R7, R10)
  task automatic build(input int inst, input int kind, input int cl, input int ph);
    int bl, lg, mr, t;
    int ops[$], adr[$], bnk[$], wt[$];
    bl = (kind == 0) ? ph : 2 * ph;
    lg = 0;
    while ((1 << lg) < bl) lg++;
    mr = lg + cl * 16 + ((kind == 3) ? 'h400 : 0);
    ops.push_back(E_CKE); adr.push_back(0); bnk.push_back(0); wt.push_back(2000);
    ops.push_back(E_PRE); adr.push_back('h400); bnk.push_back(0); wt.push_back(0);
    if (kind == 3) for (int b = 3; b >= 1; b--) begin
      ops.push_back(E_LMR); adr.push_back(0); bnk.push_back(b); wt.push_back(0);
    end
    if (kind == 1 || kind == 2) begin
      ops.push_back(E_LMR); adr.push_back(0); bnk.push_back(kind); wt.push_back(0);
    end
    ops.push_back(E_LMR); adr.push_back(mr | 'h100); bnk.push_back(0); wt.push_back(200);
    ops.push_back(E_PRE); adr.push_back('h400); bnk.push_back(0); wt.push_back(0);
    for (int k = 0; k < 2; k++) begin
      ops.push_back(E_REF); adr.push_back(0); bnk.push_back(0); wt.push_back(4);
    end
    ops.push_back(E_LMR); adr.push_back(mr); bnk.push_back(0); wt.push_back(200);
    if (kind == 3) begin
      ops.push_back(E_LMR); adr.push_back('h380); bnk.push_back(1); wt.push_back(0);
      ops.push_back(E_LMR); adr.push_back(0); bnk.push_back(1); wt.push_back(0);
    end
    t = 1;
    foreach (ops[i]) begin
      push(inst, '{cyc: t, op: ops[i], addr: adr[i], bank: bnk[i]});
      t = t + 1 + wt[i];
    end
    push(inst, '{cyc: t, op: E_DONE, addr: 0, bank: 0});
  endtask

  // monitor: compares observed events against the queue
  task automatic observe(input int inst, input int op, input int addr, input int bank);
    item_t e;
    if (qsize(inst) == 0) begin
      chk(0, "R8", $sformatf("inst%0d unexpected op %0d at cycle %0d", inst, op, cyc), op, 0);
      return;
    end
    e = qpop(inst);
    chk(e.cyc == cyc, "R6", $sformatf("inst%0d step cycle", inst), cyc, e.cyc);
    chk(e.op == op, "R4", $sformatf("inst%0d op at cycle %0d (R3 R5)", inst, cyc), op, e.op);
    chk(e.addr == addr, "R7", $sformatf("inst%0d address at cycle %0d", inst, cyc), addr, e.addr);
    chk(e.bank == bank, "R5", $sformatf("inst%0d bank at cycle %0d", inst, cyc), bank, e.bank);
  endtask

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rst) begin
        prev_cke[i] = 0; prev_done[i] = 0; cke_dropped[i] = 0;
      end else if (!prev_done[i]) begin
        if (o_done[i]) observe(i, E_DONE, 0, 0);
        else begin
          if (o_cke[i] && !prev_cke[i]) begin
            observe(i, E_CKE, int'(o_addr[i]), int'(o_bank[i]));
            if (!(o_cs[i] == 0 && o_ras[i] && o_cas[i] && o_we[i]))
              chk(0, "R2", "pins not NOP with clock enable", 0, 1);
          end
          if (prev_cke[i] && !o_cke[i]) cke_dropped[i] = 1;
          if (o_cs[i] == 0 && !(o_ras[i] && o_cas[i] && o_we[i])) begin
            int op;
            case ({o_ras[i], o_cas[i], o_we[i]})
              3'b010:  op = E_PRE;
              3'b000:  op = E_LMR;
              3'b001:  op = E_REF;
              default: op = E_BAD;
            endcase
            observe(i, op, int'(o_addr[i]), int'(o_bank[i]));
          end else if (o_cs[i] != 0)
            chk(0, "R8", "chip select released during sequence", 1, 0);
        end
        prev_cke[i] = o_cke[i];
        prev_done[i] = o_done[i];
      end
    end
  end

  // controller noise during the sequence (R9)
  initial forever begin
    @(posedge clk); #1;
    if (tog_en) begin
      ctl_addr  = AW'(cyc * 7 + 3);
      ctl_bank  = BW'(cyc);
      ctl_cs_n  = 0;
      ctl_ras_n = cyc[0];
      ctl_cas_n = cyc[1];
      ctl_we_n  = 0;
      ctl_cke   = 0;
    end
  end

  task automatic summary_and_end();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(o_cke[i] == 0, "R1", "cke in reset", o_cke[i], 0);
      chk(o_done[i] == 0, "R1", "done in reset", o_done[i], 0);
      chk({o_cs[i], o_ras[i], o_cas[i], o_we[i]} == 4'b0111, "R1", "pins in reset",
          {o_cs[i], o_ras[i], o_cas[i], o_we[i]}, 4'b0111);
    end
    build(0, 3, 3, 2);
    build(1, 0, 2, 1);
    build(2, 1, 2, 2);
    build(3, 2, 3, 2);
    rst = 0;
    while (!(o_done[0] && o_done[1] && o_done[2] && o_done[3]) && cyc < 3000)
      @(negedge clk);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(qsize(i) == 0, "R10", $sformatf("inst%0d expected events left", i), qsize(i), 0);
      chk(o_done[i] == 1, "R10", $sformatf("inst%0d done held", i), o_done[i], 1);
      chk(cke_dropped[i] == 0, "R8", $sformatf("inst%0d cke dropped", i), cke_dropped[i], 0);
    end
    // pass-through after done (R10)
    tog_en = 0;
    @(posedge clk); #1;
    ctl_addr = 13'h1A5; ctl_bank = 2'd2; ctl_cs_n = 1; ctl_ras_n = 0;
    ctl_cas_n = 1; ctl_we_n = 0; ctl_cke = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(o_addr[i] == 13'h1A5, "R10", "passthrough addr", o_addr[i], 'h1A5);
      chk({o_bank[i], o_cs[i], o_ras[i], o_cas[i], o_we[i], o_cke[i]} == 7'b10_1010_0,
          "R10", "passthrough pins",
          {o_bank[i], o_cs[i], o_ras[i], o_cas[i], o_we[i], o_cke[i]}, 7'b10_1010_0);
    end
    // reset again (R1)
    @(posedge clk); #1; rst = 1;
    @(posedge clk); @(negedge clk);
    chk(o_done[0] == 0 && o_cke[0] == 0, "R1", "state after second reset",
        {o_done[0], o_cke[0]}, 0);
    summary_and_end();
  end
endmodule